// File: doc/BRIEF.md
# Arbitrated Dual-Port RAM

This block is a shared word memory with two ports, left and right, that run independently of each other on one clock. Each port carries its own address, chip enable, output enable and one write strobe per byte lane. Either port may read or write in any cycle, and both ports reach the same storage.

When both ports are enabled on the same word in the same cycle, an arbiter grants the word to one port and raises a busy flag on the other. The busy flag blocks the losing port's write. A read on the losing port still returns data, and the busy flag marks that data as possibly stale. A mode input selects where the busy flags come from. In master mode the arbiter inside the block drives them. In slave mode the block passes through busy inputs from an external arbiter, so that several copies can be placed side by side to widen the data bus under one shared arbiter.

Top module: `dpram_arb`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (2048 x 16 by default). A word written through either port can be read back through either port.
- R2: Strobe bit b of a port enables byte lane b, which is data bits 8b+7 to 8b. Bit 0 covers bits 7:0 and bit 1 covers bits 15:8. A write changes only the lanes whose strobe is set.
- R3: A read is a cycle with chip enable high, output enable high and all strobes low. Its data and a high valid flag appear one cycle later. After any other cycle the valid flag is low and the read data is zero.
- R4: In master mode a collision is defined as both chip enables high with equal addresses. Busy is raised only during a collision, and only on one port.
- R5: In master mode, when a collision begins and neither port was enabled on that address in the previous cycle, the left port wins and the right port is flagged busy.
- R6: In master mode, a port that was enabled on the address in the previous cycle keeps the grant against a newcomer. The grant persists for as long as the collision continues on that address.
- R7: A port whose busy flag is high writes nothing. Its read still returns the stored word with the valid flag high.
- R8: When one port reads a word that the other port writes in the same cycle, the reader gets the word as it was before the write.
- R9: In slave mode each busy output equals that port's busy input, whatever the addresses. A high busy input blocks that port's writes.
- R10: In slave mode, if neither port is busy and both write the same lane of the same word in one cycle, the left port's byte is stored.
- R11: While reset is active and right after it ends, both valid flags and both read data buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: internal arbiter drives busy; 0: busy taken from inputs |
| l_ce | input | 1 | Left chip enable |
| l_oe | input | 1 | Left output enable |
| l_we | input | DATA_W/8 | Left per-lane write strobes |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_in | input | 1 | Left busy from external arbiter (slave mode) |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy | output | 1 | Left busy flag |
| r_ce | input | 1 | Right chip enable |
| r_oe | input | 1 | Right output enable |
| r_we | input | DATA_W/8 | Right per-lane write strobes |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_in | input | 1 | Right busy from external arbiter (slave mode) |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy | output | 1 | Right busy flag |

## Verification
The two functions that meet in one cycle are an access by one port and an access by the other port to the same word. The possible outcomes are a write racing a read, two writes racing each other, or a newcomer arriving while the other port already holds the address. The bench provokes each of these on purpose: both ports start on one address together, the right port settles first and the left port joins later, and in slave mode busy is forced from outside. A random phase then repeats the same cases over a four-word window. A behavioural model keeps its own copy of the memory and its own record of who holds each address. It predicts the busy flags in every cycle, and the read data and valid flags one cycle later, and the bench compares these with the outputs every clock.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_oe,
  input  logic [DATA_W/8-1:0] l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_in,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_busy,
  input  logic              r_ce,
  input  logic              r_oe,
  input  logic [DATA_W/8-1:0] r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_in,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              pl_ce, pr_ce, win_r;
  logic [ADDR_W-1:0] pl_addr, pr_addr;
  logic              coll, l_held, r_held, r_wins;
  logic              l_rd, r_rd;
  logic [LANES-1:0]  l_wr, r_wr;

  assign coll   = l_ce && r_ce && (l_addr == r_addr);
  assign l_held = pl_ce && (pl_addr == l_addr);
  assign r_held = pr_ce && (pr_addr == r_addr);
  assign r_wins = (l_held && r_held) ? win_r : (r_held && !l_held);

  assign l_busy = master_mode ? (coll && r_wins)  : l_busy_in;
  assign r_busy = master_mode ? (coll && !r_wins) : r_busy_in;

  assign l_wr = (l_ce && !l_busy) ? l_we : '0;
  assign r_wr = (r_ce && !r_busy) ? r_we : '0;
  assign l_rd = l_ce && l_oe && (l_we == '0);
  assign r_rd = r_ce && r_oe && (r_we == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_ce   <= 1'b0;
      pr_ce   <= 1'b0;
      pl_addr <= '0;
      pr_addr <= '0;
      win_r   <= 1'b0;
    end else begin
      pl_ce   <= l_ce;
      pr_ce   <= r_ce;
      pl_addr <= l_addr;
      pr_addr <= r_addr;
      if (coll) win_r <= r_wins;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (r_wr[b]) mem[r_addr][b*8 +: 8] <= r_wdata[b*8 +: 8];
      if (l_wr[b]) mem[l_addr][b*8 +: 8] <= l_wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata  <= '0;
      r_rdata  <= '0;
      l_rvalid <= 1'b0;
      r_rvalid <= 1'b0;
    end else begin
      l_rvalid <= l_rd;
      r_rvalid <= r_rd;
      l_rdata  <= l_rd ? mem[l_addr] : '0;
      r_rdata  <= r_rd ? mem[r_addr] : '0;
    end
  end

endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_ce,
  input logic              l_oe,
  input logic [DATA_W/8-1:0] l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_in,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              l_busy,
  input logic              r_ce,
  input logic              r_oe,
  input logic [DATA_W/8-1:0] r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_in,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              r_busy
);

  a_r4_busy_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> !(l_busy && r_busy));

  a_r4_busy_needs_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && (l_busy || r_busy)) |-> (l_ce && r_ce && l_addr == r_addr));

  a_r3_left_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> $past(l_ce && l_oe && l_we == '0));

  a_r3_right_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rvalid |-> (r_rdata == '0));

  a_r6_left_grant_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && $past(r_busy) && $past(l_ce) && $past(r_ce)
     && l_ce && r_ce && l_addr == r_addr && $stable(l_addr) && $stable(r_addr)) |-> r_busy);

  a_r9_slave_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy == l_busy_in && r_busy == r_busy_in));

endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dpram_arb.sv
module tb_dpram_arb;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0, master_mode = 1;
  logic l_ce = 0, l_oe = 0, l_busy_in = 0, r_ce = 0, r_oe = 0, r_busy_in = 0;
  logic [1:0] l_we = 0, r_we = 0;
  logic [AW-1:0] l_addr = 0, r_addr = 0;
  logic [DW-1:0] l_wdata = 0, r_wdata = 0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_busy, r_busy;

  dpram_arb dut (.*);

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;

  int ref_mem [NW];
  int last_l = -1, last_r = -1;
  bit prev_rwin = 0;
  int exp_ld = 0, exp_rd = 0;
  bit exp_lv = 0, exp_rv = 0;

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Inputs are already driven; predict busy now and outputs after the edge.
  task automatic cyc(string tag);
    bit coll, lh, rh, rwin, eb_l, eb_r;
    #1;
    coll = l_ce && r_ce && (l_addr == r_addr);
    lh = (last_l == int'(l_addr));
    rh = (last_r == int'(r_addr));
    if (lh && rh) rwin = prev_rwin;
    else rwin = rh;
    eb_l = master_mode ? (coll && rwin) : l_busy_in;
    eb_r = master_mode ? (coll && !rwin) : r_busy_in;
    chk(tag, "l_busy", int'(l_busy), int'(eb_l));
    chk(tag, "r_busy", int'(r_busy), int'(eb_r));
    @(posedge clk);
    exp_lv = l_ce && l_oe && (l_we == 0);
    exp_rv = r_ce && r_oe && (r_we == 0);
    exp_ld = exp_lv ? ref_mem[l_addr] : 0;
    exp_rd = exp_rv ? ref_mem[r_addr] : 0;
    for (int b = 0; b < 2; b++) begin
      if (r_ce && !eb_r && r_we[b]) ref_mem[r_addr][b*8 +: 8] = r_wdata[b*8 +: 8];
      if (l_ce && !eb_l && l_we[b]) ref_mem[l_addr][b*8 +: 8] = l_wdata[b*8 +: 8];
    end
    if (coll) prev_rwin = rwin;
    last_l = l_ce ? int'(l_addr) : -1;
    last_r = r_ce ? int'(r_addr) : -1;
    #1;
    chk(tag, "l_rvalid", int'(l_rvalid), int'(exp_lv));
    chk(tag, "r_rvalid", int'(r_rvalid), int'(exp_rv));
    chk(tag, "l_rdata", int'(l_rdata), exp_ld);
    chk(tag, "r_rdata", int'(r_rdata), exp_rd);
    @(negedge clk);
  endtask

  task automatic lset(bit ce, bit oe, logic [1:0] we, int a, int d);
    l_ce = ce; l_oe = oe; l_we = we; l_addr = AW'(a); l_wdata = DW'(d);
  endtask

  task automatic rset(bit ce, bit oe, logic [1:0] we, int a, int d);
    r_ce = ce; r_oe = oe; r_we = we; r_addr = AW'(a); r_wdata = DW'(d);
  endtask

  task automatic idle();
    lset(0, 0, 0, 0, 0);
    rset(0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "l_rvalid", int'(l_rvalid), 0);
    chk("R11", "r_rdata", int'(r_rdata), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "l_rdata", int'(l_rdata), 0);
    chk("R11", "r_rvalid", int'(r_rvalid), 0);

    // R1: fill through both ports at different addresses each cycle
    for (int i = 0; i < NW; i += 2) begin
      lset(1, 0, 2'b11, i, i * 7 + 3);
      rset(1, 0, 2'b11, i + 1, (i + 1) * 7 + 3);
      cyc("R1");
    end
    lset(1, 1, 0, 1001, 0); rset(1, 1, 0, 1000, 0); cyc("R1");
    lset(1, 1, 0, 2047, 0); rset(1, 1, 0, 0, 0);    cyc("R1");
    idle(); cyc("R1");

    // R2: lane masking
    lset(1, 0, 2'b01, 10, 16'hAB12); cyc("R2");
    lset(1, 0, 2'b10, 11, 16'hCD34); cyc("R2");
    lset(1, 0, 2'b00, 12, 16'hFFFF); cyc("R3");
    lset(1, 1, 0, 10, 0); rset(1, 1, 0, 11, 0); cyc("R2");
    lset(1, 1, 0, 12, 0); idle(); cyc("R2");

    // R3: valid only for true reads
    lset(1, 0, 0, 5, 0); cyc("R3");
    lset(0, 1, 0, 5, 0); cyc("R3");
    lset(1, 1, 2'b01, 13, 16'h0101); cyc("R3");
    idle(); cyc("R3");

    // R5 and R8: simultaneous start, left writes, right reads old data
    lset(1, 1, 2'b11, 20, 16'h2020); rset(1, 1, 0, 20, 0); cyc("R8");
    idle(); cyc("R5");
    // R5: both write together, right blocked
    lset(1, 0, 2'b11, 30, 16'h3333); rset(1, 0, 2'b11, 30, 16'h4444); cyc("R5");
    idle(); cyc("R5");
    lset(1, 1, 0, 30, 0); cyc("R5");

    // R6 and R7: right holds, left arrives later and is blocked
    idle(); cyc("R6");
    rset(1, 1, 0, 40, 0); cyc("R6");
    lset(1, 1, 2'b11, 40, 16'h4040); cyc("R6");
    lset(1, 1, 0, 40, 0); cyc("R7");
    lset(1, 1, 2'b11, 40, 16'h5050); cyc("R7");
    rset(0, 0, 0, 0, 0); lset(1, 1, 0, 40, 0); cyc("R7");
    idle(); cyc("R4");

    // R9: slave mode pass-through and blocking
    master_mode = 0;
    l_busy_in = 1; lset(1, 0, 2'b11, 50, 16'h5A5A); rset(1, 1, 0, 51, 0); cyc("R9");
    l_busy_in = 0; r_busy_in = 1; lset(1, 1, 0, 50, 0); rset(1, 0, 2'b11, 52, 16'h1234); cyc("R9");
    r_busy_in = 0; lset(1, 1, 0, 52, 0); rset(0, 0, 0, 0, 0); cyc("R9");
    // R10: both write one word, left lane wins
    lset(1, 0, 2'b01, 60, 16'h1111); rset(1, 0, 2'b11, 60, 16'h2222); cyc("R10");
    lset(1, 0, 2'b11, 61, 16'h7777); rset(1, 0, 2'b11, 61, 16'h8888); cyc("R10");
    lset(1, 1, 0, 60, 0); rset(1, 1, 0, 61, 0); cyc("R10");
    idle(); cyc("R10");

    // R4: random traffic over a narrow window, both modes
    for (int n = 0; n < 600; n++) begin
      if (n % 40 == 0) master_mode = (n % 80 == 0);
      l_busy_in = ($urandom % 4) == 0;
      r_busy_in = ($urandom % 4) == 0;
      lset(($urandom % 4) != 0, $urandom % 2, ($urandom % 3 == 0) ? 2'($urandom) : 2'b00,
           $urandom % 4, $urandom);
      rset(($urandom % 4) != 0, $urandom % 2, ($urandom % 3 == 0) ? 2'($urandom) : 2'b00,
           $urandom % 4, $urandom);
      cyc("R4");
    end
    idle(); cyc("R4");

    done = 1;
    summary();
    $finish;
  end
endmodule